// File: doc/BRIEF.md
# Operand Word Packer

This block loads a multi-precision integer into a 64-bit-wide working RAM. The integer arrives as a byte stream, most significant byte first. A single start pulse announces the operand. It carries three values: the number of bytes that will follow, the number of RAM words the operand must occupy, and the base address of the destination area. The block holds the whole operand internally. Once the final byte has been taken, it writes the RAM one word per cycle. It begins with the least significant word at the base address and moves upward in steps of 8.

Any part of the top word above the operand is filled with zeros. Every word between the operand and the requested word count is written as zero. The requested count must leave room for at least one extra zero word above the operand, so the highest word written is always zero.

A request is refused when the word count is too small for the operand or larger than the RAM limit. A refused request writes nothing. It raises an error flag together with the completion pulse. A byte stream whose end marker disagrees with the announced byte count is refused the same way.

Top module: `operand_word_packer`

## Requirements
- R1: After reset `in_ready_o`, `wr_en_o` and `done_o` are low and `err_o` is low.
- R2: When a start request has `word_cnt_i` below ceil(`byte_cnt_i`/8)+1, the block does the following. It pulses `done_o` with `err_o` high in the cycle after the start is sampled. It never raises `in_ready_o` and writes nothing.
- R3: When a start request has `word_cnt_i` above `MAX_WORDS` (11), it is refused in the same way as in R2.
- R4: Byte k, counted from the end of the stream (the last byte being k=0), is written to word k/8 at bits (k mod 8)*8+7 down to (k mod 8)*8.
- R5: An accepted request produces exactly `word_cnt_i` writes, in consecutive cycles. Write i goes to address `base_addr_i` + 8*i, with i rising from 0.
- R6: Bytes above the operand in its top word are zero. Every word from ceil(`byte_cnt_i`/8) up to `word_cnt_i`-1 is written as all zeros.
- R7: `in_ready_o` is high from the cycle after an accepted start until the cycle in which the last byte is taken. It is low at every other time, and never high together with `wr_en_o` or `done_o`.
- R8: Two stream faults refuse the request: a byte marked last arriving before the announced count, and the announced count reached without a last marker. Either one pulses `done_o` with `err_o` high, with no writes. `err_o` rises only together with `done_o` and holds until the next accepted start.
- R9: After a successful request, `done_o` pulses high for exactly one cycle, in the cycle after the final write, with `err_o` low.
- R10: A start pulse is ignored while a request is in progress. The running request's writes are unchanged and no second request follows.
- R11: With `byte_cnt_i` zero, no byte is taken. The block writes `word_cnt_i` zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; sizes and base are sampled with it |
| byte_cnt_i | input | 7 | Number of operand bytes in the stream |
| word_cnt_i | input | 4 | Number of 64-bit words to write |
| base_addr_i | input | 16 | Byte address of the least significant word |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte, most significant first |
| in_last_i | input | 1 | Marks the final stream byte |
| in_ready_o | output | 1 | Block accepts a stream byte |
| wr_en_o | output | 1 | RAM word write strobe |
| wr_addr_o | output | 16 | RAM byte address of the word |
| wr_data_o | output | 64 | RAM word data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request refused; valid with `done_o` |

## Verification
The bench sweeps every operand length from 0 to 80 bytes at the minimum legal word count. It repeats selected lengths at the full 11-word count. A design that swapped byte order inside a word, or started from the wrong end, would put the final stream byte somewhere other than bits 7:0 of the base word. A design that left stale buffer contents behind would show nonzero bytes above a short operand that followed a long one.

The lengths 8, 9, 72 and 80 exercise the rounding in the minimum word count. An off-by-one in the size check would either refuse a legal request or write past the area. Early and missing end markers test that a mismatched stream leaves the RAM untouched. A stray start during writing must not alter or repeat the running request.

// File: rtl/opw_pkg.sv
package opw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_EMIT = 2'd2,
    ST_FIN  = 2'd3
  } opw_state_e;

endpackage

// File: rtl/opw_size_check.sv
module opw_size_check #(
  parameter int MAX_WORDS  = 11,
  parameter int WORD_BYTES = 8,
  parameter int BCNT_W     = 7,
  parameter int WCNT_W     = 4
) (
  input  logic [BCNT_W-1:0] byte_cnt_i,
  input  logic [WCNT_W-1:0] word_cnt_i,
  output logic              size_ok_o
);

  logic [31:0] need_words;
  logic [31:0] req_words;

  always_comb begin
    need_words = (32'(byte_cnt_i) + 32'(WORD_BYTES - 1)) / 32'(WORD_BYTES) + 32'd1;
    req_words  = 32'(word_cnt_i);
    size_ok_o  = (req_words >= need_words) && (req_words <= 32'(MAX_WORDS));
  end

endmodule

// File: rtl/opw_byte_buf.sv
module opw_byte_buf #(
  parameter int DATA_WORDS = 10,
  parameter int WORD_W     = 64,
  parameter int BYTE_W     = 8,
  parameter int IDX_W      = 4,
  localparam int BUF_W     = DATA_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o
);

  logic [BUF_W-1:0] buf_q;
  logic [BUF_W-1:0] buf_d;
  logic             buf_en;

  // Newest byte always enters at the bottom, so the stream's final byte
  // lands in the least significant position without any index arithmetic.
  always_comb begin
    buf_en = clr_i | shift_i;
    if (clr_i) begin
      buf_d = '0;
    end else begin
      buf_d = {buf_q[BUF_W-BYTE_W-1:0], byte_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (buf_en) begin
      buf_q <= buf_d;
    end
  end

  // Word indices beyond the buffer read as zero (the trailing word).
  always_comb begin
    rd_word_o = '0;
    for (int i = 0; i < DATA_WORDS; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        rd_word_o = buf_q[i*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/operand_word_packer.sv
module operand_word_packer #(
  parameter int  MAX_WORDS   = 11,
  parameter int  ADDR_W      = 16,
  localparam int BYTE_W      = 8,
  localparam int WORD_BYTES  = 8,
  localparam int WORD_W      = BYTE_W * WORD_BYTES,
  localparam int DATA_WORDS  = MAX_WORDS - 1,
  localparam int DATA_BYTES  = DATA_WORDS * WORD_BYTES,
  localparam int BCNT_W      = $clog2(DATA_BYTES + 1),
  localparam int WCNT_W      = $clog2(MAX_WORDS + 1),
  localparam int STEP_SH     = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BCNT_W-1:0] byte_cnt_i,
  input  logic [WCNT_W-1:0] word_cnt_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              err_o
);

  import opw_pkg::*;

  opw_state_e        state_q, state_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [BCNT_W-1:0] rcv_q, rcv_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [WCNT_W-1:0] idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              err_q, err_d;

  logic              size_ok;
  logic              buf_clr;
  logic              buf_shift;
  logic [BCNT_W-1:0] rcv_inc;
  logic              rcv_full;
  logic              cfg_en;

  opw_size_check #(
    .MAX_WORDS (MAX_WORDS),
    .WORD_BYTES(WORD_BYTES),
    .BCNT_W    (BCNT_W),
    .WCNT_W    (WCNT_W)
  ) u_size (
    .byte_cnt_i(byte_cnt_i),
    .word_cnt_i(word_cnt_i),
    .size_ok_o (size_ok)
  );

  opw_byte_buf #(
    .DATA_WORDS(DATA_WORDS),
    .WORD_W    (WORD_W),
    .BYTE_W    (BYTE_W),
    .IDX_W     (WCNT_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (buf_clr),
    .shift_i  (buf_shift),
    .byte_i   (in_data_i),
    .rd_idx_i (idx_q),
    .rd_word_o(wr_data_o)
  );

  always_comb begin
    state_d   = state_q;
    bcnt_d    = bcnt_q;
    rcv_d     = rcv_q;
    wcnt_d    = wcnt_q;
    idx_d     = idx_q;
    base_d    = base_q;
    err_d     = err_q;
    buf_clr   = 1'b0;
    buf_shift = 1'b0;
    cfg_en    = 1'b0;
    rcv_inc   = rcv_q + 1'b1;
    rcv_full  = (rcv_inc == bcnt_q);

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cfg_en  = 1'b1;
          bcnt_d  = byte_cnt_i;
          wcnt_d  = word_cnt_i;
          base_d  = base_addr_i;
          rcv_d   = '0;
          idx_d   = '0;
          err_d   = 1'b0;
          buf_clr = 1'b1;
          if (!size_ok) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end else if (byte_cnt_i == '0) begin
            state_d = ST_EMIT;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (in_valid_i) begin
          buf_shift = 1'b1;
          rcv_d     = rcv_inc;
          if (in_last_i && rcv_full) begin
            state_d = ST_EMIT;
          end else if (in_last_i || rcv_full) begin
            err_d   = 1'b1;
            state_d = ST_FIN;
          end
        end
      end
      ST_EMIT: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == wcnt_q - 1'b1) begin
          state_d = ST_FIN;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rcv_q   <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rcv_q   <= rcv_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      wcnt_q <= '0;
      base_q <= '0;
    end else if (cfg_en) begin
      bcnt_q <= bcnt_d;
      wcnt_q <= wcnt_d;
      base_q <= base_d;
    end
  end

  always_comb begin
    in_ready_o = (state_q == ST_FILL);
    wr_en_o    = (state_q == ST_EMIT);
    done_o     = (state_q == ST_FIN);
    err_o      = err_q;
    wr_addr_o  = base_q + (ADDR_W'(idx_q) << STEP_SH);
  end

endmodule

// File: rtl/opw_checker.sv
module opw_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              done_o,
  input logic              err_o
);

  assert_phase_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready_o, wr_en_o, done_o}));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + ADDR_W'(8)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_refused_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> !$past(wr_en_o));

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);

endmodule

bind operand_word_packer opw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready_o(in_ready_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/operand_word_packer_tb.sv
module operand_word_packer_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [6:0]  byte_cnt_i;
  logic [3:0]  word_cnt_i;
  logic [15:0] base_addr_i;
  logic        in_valid_i;
  logic [7:0]  in_data_i;
  logic        in_last_i;
  logic        in_ready_o;
  logic        wr_en_o;
  logic [15:0] wr_addr_o;
  logic [63:0] wr_data_o;
  logic        done_o;
  logic        err_o;

  operand_word_packer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .byte_cnt_i (byte_cnt_i),
    .word_cnt_i (word_cnt_i),
    .base_addr_i(base_addr_i),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_last_i  (in_last_i),
    .in_ready_o (in_ready_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int wd_cnt   = 0;

  // Collector state
  logic [63:0] cap [16];
  int          wr_count;
  int          done_count;
  int          addr_bad;
  int          cyc = 0;
  int          last_wr_cyc;
  int          done_cyc;
  bit          done_err;
  logic [15:0] cur_base;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (wr_en_o) begin
      if (wr_addr_o != cur_base + 16'(8 * wr_count)) addr_bad++;
      if (wr_count < 16) cap[wr_count] = wr_data_o;
      wr_count++;
      last_wr_cyc = cyc;
    end
    if (done_o) begin
      done_count++;
      done_err = err_o;
      done_cyc = cyc;
    end
  end

  function automatic logic [7:0] bval(input int n, input int j);
    return 8'((n * 29 + j * 53 + 17) & 255);
  endfunction

  function automatic logic [63:0] exp_word(input int n, input int w);
    logic [63:0] e;
    e = '0;
    for (int j = 0; j < n; j++) begin
      int p;
      p = n - 1 - j;
      if (p / 8 == w) e = e | (64'(bval(n, j)) << ((p % 8) * 8));
    end
    return e;
  endfunction

  // mode: 0 normal, 1 early last marker, 2 missing last marker, 3 stray start
  task automatic run_op(input int n, input int wc, input logic [15:0] base,
                        input int mode);
    bit size_bad, exp_err;
    int nsend, guard;
    size_bad = (wc < (n + 7) / 8 + 1) || (wc > 11);
    exp_err  = size_bad || (mode == 1) || (mode == 2);
    nsend    = (mode == 1) ? n / 2 : n;
    @(negedge clk);
    wr_count = 0; done_count = 0; addr_bad = 0; done_err = 1'b0;
    last_wr_cyc = 0; done_cyc = 0; cur_base = base;
    start_i = 1'b1; byte_cnt_i = 7'(n); word_cnt_i = 4'(wc); base_addr_i = base;
    @(negedge clk);
    start_i = 1'b0;
    if (size_bad) begin
      check(done_o && err_o, (wc > 11) ? "R3" : "R2", "refusal one cycle after start",
            {done_o, err_o}, 2'b11);
      check(!in_ready_o, "R2", "ready stays low on refusal", in_ready_o, 0);
    end else begin
      if (n > 0) check(in_ready_o, "R7", "ready after start", in_ready_o, 1);
      else check(!in_ready_o, "R11", "no ready with zero bytes", in_ready_o, 0);
      for (int j = 0; j < nsend; j++) begin
        in_valid_i = 1'b1;
        in_data_i  = bval(n, j);
        in_last_i  = (mode == 2) ? 1'b0 : (j == nsend - 1);
        guard = 0;
        while (!in_ready_o && guard < 50) begin
          @(negedge clk);
          guard++;
        end
        @(negedge clk);
      end
      in_valid_i = 1'b0; in_last_i = 1'b0;
      if (nsend > 0) check(!in_ready_o, "R7", "ready low after last byte", in_ready_o, 0);
      if (mode == 3) begin
        guard = 0;
        while (!wr_en_o && guard < 50) begin
          @(negedge clk);
          guard++;
        end
        start_i = 1'b1; byte_cnt_i = 7'd0; word_cnt_i = 4'd1; base_addr_i = 16'hF000;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    guard = 0;
    while (done_count == 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    check(done_count == 1, (mode == 3) ? "R10" : "R9", "single done pulse", done_count, 1);
    check(done_err == exp_err, exp_err ? "R8" : "R9", "error flag at done", done_err, exp_err);
    if (exp_err) begin
      check(wr_count == 0, size_bad ? "R2" : "R8", "no writes on refusal", wr_count, 0);
      check(err_o, "R8", "error flag held", err_o, 1);
    end else begin
      check(wr_count == wc, (mode == 3) ? "R10" : "R5", "write count", wr_count, wc);
      check(addr_bad == 0, "R5", "ascending addresses", addr_bad, 0);
      check(done_cyc == last_wr_cyc + 1, "R9", "done right after final write",
            done_cyc - last_wr_cyc, 1);
      for (int w = 0; w < wc && w < 16; w++) begin
        logic [63:0] e;
        e = exp_word(n, w);
        if (n == 0) check(cap[w] == e, "R11", "zero operand word", cap[w], e);
        else if (w < (n + 7) / 8) check(cap[w] == e, "R4", "operand word", cap[w], e);
        else check(cap[w] == e, "R6", "padding word", cap[w], e);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; byte_cnt_i = '0; word_cnt_i = '0;
    base_addr_i = '0; in_valid_i = 1'b0; in_data_i = '0; in_last_i = 1'b0;
    repeat (3) @(negedge clk);
    check({in_ready_o, wr_en_o, done_o, err_o} == 4'b0, "R1", "reset outputs",
          {in_ready_o, wr_en_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({in_ready_o, wr_en_o, done_o, err_o} == 4'b0, "R1", "idle after reset",
          {in_ready_o, wr_en_o, done_o, err_o}, 0);

    // Long operand first so stale contents would show in shorter ones (R6)
    run_op(80, 11, 16'h2000, 0);
    for (int n = 0; n <= 80; n++) begin
      run_op(n, (n + 7) / 8 + 1, 16'(16'h0100 + n * 24), 0);
    end
    run_op(1, 11, 16'h4000, 0);
    run_op(8, 11, 16'h4100, 0);
    run_op(9, 11, 16'h4200, 0);
    run_op(40, 11, 16'h4300, 0);
    run_op(0, 11, 16'h4400, 0);

    run_op(9, 2, 16'h5000, 0);   // R2: one word short
    run_op(80, 10, 16'h5000, 0); // R2: full operand without zero word
    run_op(0, 0, 16'h5000, 0);   // R2: no room for zero word
    run_op(8, 12, 16'h5000, 0);  // R3: above limit
    run_op(10, 5, 16'h6000, 1);  // R8: early last marker
    run_op(4, 2, 16'h6000, 2);   // R8: last marker missing
    run_op(20, 5, 16'h7000, 3);  // R10: stray start during writes
    run_op(16, 3, 16'h7100, 0);  // normal after faults clears error (R9)

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule